// File: doc/BRIEF.md
# CSR Read-Modify-Write Unit

This block carries out the six control-and-status-register access operations of an integer core against a small local bank of four registers. Each request names a 12-bit register address and a 3-bit function code. It also carries a source operand, which is either the rs1 register value or a 5-bit unsigned immediate, and two flags that say whether the destination and the source register are x0. The unit returns the register's previous contents for the destination. In the same cycle it schedules a replace, bit-set or bit-clear of that register. Only the bits that the register's fixed writable mask allows are changed.

A request that is not needed leaves out its access. A replace whose destination is x0 performs no read. A set or clear with a zero source operand performs no write. Two strobe outputs report which accesses really happened, so that neighbouring logic can attach read or write side effects to them. An unmapped address or a reserved function code raises an illegal-instruction flag and changes nothing.

Top module: `csr_rmw_unit`

## Requirements
- R1: Function code 3'b001 (replace, register source) returns the old register value on `rsp_rdata` in the request cycle. From the next cycle the register holds `(old & ~mask) | (src & mask)`.
- R2: Function codes 3'b010 and 3'b110 (set) return the old value. The register becomes `old | (src & mask)`.
- R3: Function codes 3'b011 and 3'b111 (clear) return the old value. The register becomes `old & ~(src & mask)`.
- R4: A replace (3'b001 or 3'b101) with `req_rd_zero`=1 performs no read: `rd_strobe`=0 and `rsp_rdata`=0. The write still takes place and `wr_strobe`=1.
- R5: A set or clear performs no write when the source is zero: `req_rs1_zero`=1 in the register forms, or `req_uimm`=0 in the immediate forms. In that case `wr_strobe`=0 and the register keeps its value, while the read still takes place.
- R6: When bit 2 of the function code is set, the source is `req_uimm` zero-extended to XLEN, and `req_rs1_val` has no effect.
- R7: The bank holds four registers, each reset to a fixed value: 0x300 (mask 0x00001888, reset 0x00001800), 0x305 (mask 0xFFFFFFFC, reset 0), 0x340 (mask 0xFFFFFFFF, reset 0) and 0xF14 (mask 0, reset 0x00000007). Bits outside the mask always read as their reset value.
- R8: A request is illegal when its address is not in the bank or its function code is 3'b000 or 3'b100. An illegal request sets `rsp_illegal`=1, drives `rsp_rdata`=0 and both strobes to 0, and changes no register.
- R9: While `req_valid`=0 every output is 0 and no register changes.
- R10: The strobes equal the accesses performed: `rd_strobe`=1 exactly when the old value is returned, and `wr_strobe`=1 exactly when a register write is scheduled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 12 | Register address |
| req_func | input | 3 | Function code |
| req_rs1_val | input | XLEN | Source register value |
| req_uimm | input | 5 | Immediate source |
| req_rd_zero | input | 1 | Destination register is x0 |
| req_rs1_zero | input | 1 | Source register is x0 |
| rsp_rdata | output | XLEN | Old register value for the destination |
| rsp_illegal | output | 1 | Illegal-instruction flag |
| rd_strobe | output | 1 | A register read was performed |
| wr_strobe | output | 1 | A register write was performed |

## Verification
The return of the old value and the write of the new value happen in the same request cycle. A back-to-back access to the same register must therefore see the previous update and never a half-applied one. The bench provokes this with runs of consecutive accesses, both directed and random, to one address. Each returned value is judged against a behavioural bank model that changes only after the output has been compared. The x0 suppression flags are also crossed with every operation kind, so that a missing read and a missing write are each judged alongside the access that does happen in that cycle.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

    localparam int XLEN_DEF    = 32;
    localparam int NUM_CSR_DEF = 4;
    localparam int ADDR_W      = 12;
    localparam int UIMM_W      = 5;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_SET   = 2'b10,
        KIND_CLEAR = 2'b11
    } csr_kind_e;

    typedef struct packed {
        csr_kind_e kind;
        logic      use_imm;
    } csr_op_t;

    function automatic csr_op_t decode_func(input logic [2:0] f);
        csr_op_t o;
        o.kind    = csr_kind_e'(f[1:0]);
        o.use_imm = f[2];
        return o;
    endfunction

    function automatic logic [ADDR_W-1:0] csr_addr(input int i);
        case (i)
            0:       return 12'h300;
            1:       return 12'h305;
            2:       return 12'h340;
            default: return 12'hF14;
        endcase
    endfunction

    function automatic logic [63:0] csr_mask(input int i);
        case (i)
            0:       return 64'h0000_1888;
            1:       return 64'hFFFF_FFFC;
            2:       return 64'hFFFF_FFFF;
            default: return 64'h0;
        endcase
    endfunction

    function automatic logic [63:0] csr_reset(input int i);
        case (i)
            0:       return 64'h0000_1800;
            1:       return 64'h0;
            2:       return 64'h0;
            default: return 64'h0000_0007;
        endcase
    endfunction

endpackage

// File: rtl/csr_rmw_decode.sv
module csr_rmw_decode
    import csr_rmw_pkg::*;
#(
    parameter int XLEN    = XLEN_DEF,
    parameter int NUM_CSR = NUM_CSR_DEF
) (
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [2:0]           req_func,
    input  logic [XLEN-1:0]      req_rs1_val,
    input  logic [UIMM_W-1:0]    req_uimm,
    input  logic                 req_rd_zero,
    input  logic                 req_rs1_zero,
    output logic [NUM_CSR-1:0]   sel,
    output csr_kind_e            kind,
    output logic [XLEN-1:0]      src,
    output logic                 do_read,
    output logic                 do_write,
    output logic                 illegal
);
    csr_op_t op;
    logic    hit;
    logic    src_zero;

    for (genvar i = 0; i < NUM_CSR; i++) begin : g_match
        localparam logic [ADDR_W-1:0] ADDR_I = csr_addr(i);
        assign sel[i] = (req_addr == ADDR_I);
    end

    always_comb begin
        op       = decode_func(req_func);
        kind     = op.kind;
        hit      = |sel;
        src      = op.use_imm ? {{(XLEN-UIMM_W){1'b0}}, req_uimm} : req_rs1_val;
        src_zero = op.use_imm ? (req_uimm == '0) : req_rs1_zero;
        illegal  = req_valid && (!hit || (op.kind == KIND_NONE));
        do_read  = 1'b0;
        do_write = 1'b0;
        if (req_valid && !illegal) begin
            if (op.kind == KIND_WRITE) begin
                do_read  = !req_rd_zero;
                do_write = 1'b1;
            end else begin
                do_read  = 1'b1;
                do_write = !src_zero;
            end
        end
    end
endmodule

// File: rtl/csr_rmw_alu.sv
module csr_rmw_alu
    import csr_rmw_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  csr_kind_e       kind,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] src,
    output logic [XLEN-1:0] target
);
    always_comb begin
        unique case (kind)
            KIND_WRITE: target = src;
            KIND_SET:   target = old_val | src;
            KIND_CLEAR: target = old_val & ~src;
            default:    target = old_val;
        endcase
    end
endmodule

// File: rtl/csr_rmw_bank.sv
module csr_rmw_bank
    import csr_rmw_pkg::*;
#(
    parameter int XLEN    = XLEN_DEF,
    parameter int NUM_CSR = NUM_CSR_DEF
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [NUM_CSR-1:0]               wr_sel,
    input  logic [XLEN-1:0]                  wr_data,
    output logic [NUM_CSR-1:0][XLEN-1:0]     q
);
    for (genvar i = 0; i < NUM_CSR; i++) begin : g_reg
        localparam logic [63:0]     M64  = csr_mask(i);
        localparam logic [63:0]     R64  = csr_reset(i);
        localparam logic [XLEN-1:0] MASK = M64[XLEN-1:0];
        localparam logic [XLEN-1:0] RSTV = R64[XLEN-1:0];

        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= RSTV;
            end else if (wr_en && wr_sel[i]) begin
                q[i] <= (q[i] & ~MASK) | (wr_data & MASK);
            end
        end

        assert_ro_bits_R7: assert property (@(posedge clk) disable iff (rst)
            (q[i] & ~MASK) == (RSTV & ~MASK))
            else $error("read-only bits of register %0d drifted", i);
    end

    assert_nowrite_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q))
        else $error("bank changed without a write");
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int XLEN    = XLEN_DEF,
    parameter int NUM_CSR = NUM_CSR_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [11:0]       req_addr,
    input  logic [2:0]        req_func,
    input  logic [XLEN-1:0]   req_rs1_val,
    input  logic [4:0]        req_uimm,
    input  logic              req_rd_zero,
    input  logic              req_rs1_zero,
    output logic [XLEN-1:0]   rsp_rdata,
    output logic              rsp_illegal,
    output logic              rd_strobe,
    output logic              wr_strobe
);
    logic [NUM_CSR-1:0]           sel;
    csr_kind_e                    kind;
    logic [XLEN-1:0]              src;
    logic                         do_read;
    logic                         do_write;
    logic                         illegal;
    logic [XLEN-1:0]              old_val;
    logic [XLEN-1:0]              target;
    logic [NUM_CSR-1:0][XLEN-1:0] q;

    csr_rmw_decode #(.XLEN(XLEN), .NUM_CSR(NUM_CSR)) u_dec (
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_func     (req_func),
        .req_rs1_val  (req_rs1_val),
        .req_uimm     (req_uimm),
        .req_rd_zero  (req_rd_zero),
        .req_rs1_zero (req_rs1_zero),
        .sel          (sel),
        .kind         (kind),
        .src          (src),
        .do_read      (do_read),
        .do_write     (do_write),
        .illegal      (illegal)
    );

    always_comb begin
        old_val = '0;
        for (int i = 0; i < NUM_CSR; i++) begin
            if (sel[i]) old_val |= q[i];
        end
    end

    csr_rmw_alu #(.XLEN(XLEN)) u_alu (
        .kind    (kind),
        .old_val (old_val),
        .src     (src),
        .target  (target)
    );

    csr_rmw_bank #(.XLEN(XLEN), .NUM_CSR(NUM_CSR)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (do_write),
        .wr_sel  (sel),
        .wr_data (target),
        .q       (q)
    );

    assign rsp_rdata   = do_read ? old_val : '0;
    assign rsp_illegal = illegal;
    assign rd_strobe   = do_read;
    assign wr_strobe   = do_write;

    assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_illegal |-> (!rd_strobe && !wr_strobe && rsp_rdata == '0))
        else $error("illegal request performed an access");

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!rd_strobe && !wr_strobe && !rsp_illegal && rsp_rdata == '0))
        else $error("outputs active without a request");

    assert_rdzero_noread_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_rd_zero && req_func[1:0] == 2'b01) |-> !rd_strobe)
        else $error("replace to x0 performed a read");

    assert_strobe_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_illegal, rd_strobe | wr_strobe}))
        else $error("illegal flag together with an access strobe");
endmodule

// File: tb/csr_rmw_unit_test.sv
`timescale 1ns/1ps
module csr_rmw_unit_test;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic [11:0]     req_addr = '0;
    logic [2:0]      req_func = '0;
    logic [XLEN-1:0] req_rs1_val = '0;
    logic [4:0]      req_uimm = '0;
    logic            req_rd_zero = 1'b0;
    logic            req_rs1_zero = 1'b0;
    logic [XLEN-1:0] rsp_rdata;
    logic            rsp_illegal;
    logic            rd_strobe;
    logic            wr_strobe;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [11:0] m_addr [4] = '{12'h300, 12'h305, 12'h340, 12'hF14};
    logic [31:0] m_mask [4] = '{32'h0000_1888, 32'hFFFF_FFFC, 32'hFFFF_FFFF, 32'h0};
    logic [31:0] m_rst  [4] = '{32'h0000_1800, 32'h0, 32'h0, 32'h0000_0007};
    logic [31:0] mdl    [4];

    always #4 clk = ~clk;

    csr_rmw_unit uut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_func     (req_func),
        .req_rs1_val  (req_rs1_val),
        .req_uimm     (req_uimm),
        .req_rd_zero  (req_rd_zero),
        .req_rs1_zero (req_rs1_zero),
        .rsp_rdata    (rsp_rdata),
        .rsp_illegal  (rsp_illegal),
        .rd_strobe    (rd_strobe),
        .wr_strobe    (wr_strobe)
    );

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit v, input logic [11:0] a, input logic [2:0] f,
                        input logic [31:0] r, input logic [4:0] u,
                        input bit rdz, input bit rsz, input string force_tag);
        int idx = -1;
        bit ill = 0, rd = 0, wr = 0;
        logic [31:0] s, exp_data = 0, nv = 0;
        string tag;
        req_valid = v; req_addr = a; req_func = f; req_rs1_val = r;
        req_uimm = u; req_rd_zero = rdz; req_rs1_zero = rsz;
        for (int k = 0; k < 4; k++) if (a == m_addr[k]) idx = k;
        s = f[2] ? {27'b0, u} : r;
        if (!v) tag = "R9";
        else if (idx < 0 || f[1:0] == 2'b00) begin ill = 1; tag = "R8"; end
        else begin
            rd = (f[1:0] == 2'b01) ? !rdz : 1'b1;
            wr = (f[1:0] == 2'b01) ? 1'b1 : (f[2] ? (u != 0) : !rsz);
            if (rd) exp_data = mdl[idx];
            case (f[1:0])
                2'b01: nv = s;
                2'b10: nv = mdl[idx] | s;
                default: nv = mdl[idx] & ~s;
            endcase
            if (f[1:0] == 2'b01 && rdz) tag = "R4";
            else if (f[1:0] != 2'b01 && !wr) tag = "R5";
            else if (f[2]) tag = "R6";
            else if (f[1:0] == 2'b01) tag = "R1";
            else if (f[1:0] == 2'b10) tag = "R2";
            else tag = "R3";
        end
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        cmp(tag, "rdata", rsp_rdata, exp_data);
        cmp(tag, "illegal", {31'b0, rsp_illegal}, {31'b0, ill});
        cmp({tag, "/R10"}, "rd_strobe", {31'b0, rd_strobe}, {31'b0, rd});
        cmp({tag, "/R10"}, "wr_strobe", {31'b0, wr_strobe}, {31'b0, wr});
        if (!rst && wr) mdl[idx] = (mdl[idx] & ~m_mask[idx]) | (nv & m_mask[idx]);
        @(posedge clk); #1;
    endtask

    task automatic peek(input int k, input string tag);
        step(1, m_addr[k], 3'b010, 32'hFFFF_FFFF, 5'd0, 0, 1, tag);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) mdl[k] = m_rst[k];
        @(posedge clk); #1;
        step(0, 12'h300, 3'b001, 32'hFFFF_FFFF, 5'd1, 0, 0, "R9");
        step(0, 12'h300, 3'b001, 32'hFFFF_FFFF, 5'd1, 0, 0, "R9");
        rst = 1'b0;
        // R7: reset values read back
        for (int k = 0; k < 4; k++) peek(k, "R7");
        // R1: replace, and read-only bits untouched
        step(1, 12'h300, 3'b001, 32'hFFFF_FFFF, 5'd0, 0, 0, "R1");
        peek(0, "R7");
        step(1, 12'h305, 3'b001, 32'h1234_5677, 5'd0, 0, 0, "R1");
        step(1, 12'h305, 3'b001, 32'hA5A5_A5A5, 5'd0, 0, 0, "R1");
        // R2 / R3 back to back on one register
        step(1, 12'h340, 3'b010, 32'h0000_00F0, 5'd0, 0, 0, "R2");
        step(1, 12'h340, 3'b010, 32'hF000_0000, 5'd0, 1, 0, "R2");
        step(1, 12'h340, 3'b011, 32'h0000_0030, 5'd0, 0, 0, "R3");
        step(1, 12'h340, 3'b111, 32'hFFFF_FFFF, 5'd16, 0, 0, "R3");
        peek(2, "R3");
        // R4: replace to x0
        step(1, 12'h340, 3'b001, 32'hDEAD_BEEF, 5'd0, 1, 0, "R4");
        step(1, 12'h340, 3'b101, 32'h0, 5'd9, 1, 0, "R4");
        peek(2, "R4");
        // R5: zero source set/clear
        step(1, 12'h340, 3'b010, 32'h0000_FFFF, 5'd0, 0, 1, "R5");
        step(1, 12'h340, 3'b111, 32'hFFFF_FFFF, 5'd0, 0, 0, "R5");
        peek(2, "R5");
        // R6: immediate source ignores rs1 value
        step(1, 12'h305, 3'b101, 32'hFFFF_FFFF, 5'd31, 0, 0, "R6");
        step(1, 12'h305, 3'b110, 32'hFFFF_FFFF, 5'd0, 0, 0, "R6");
        peek(1, "R6");
        // R7: read-only register writes have no effect
        step(1, 12'hF14, 3'b001, 32'h0, 5'd0, 0, 0, "R7");
        step(1, 12'hF14, 3'b011, 32'hFFFF_FFFF, 5'd0, 0, 0, "R7");
        peek(3, "R7");
        // R8: unmapped address and reserved codes
        step(1, 12'h301, 3'b001, 32'hFFFF_FFFF, 5'd0, 0, 0, "R8");
        step(1, 12'h300, 3'b000, 32'hFFFF_FFFF, 5'd0, 0, 0, "R8");
        step(1, 12'h340, 3'b100, 32'hFFFF_FFFF, 5'd5, 0, 0, "R8");
        for (int k = 0; k < 4; k++) peek(k, "R8");
        // mixed traffic
        for (int n = 0; n < 4000; n++) begin
            logic [11:0] a;
            logic [4:0]  u;
            a = ($urandom % 5 == 0) ? 12'($urandom) : m_addr[$urandom % 4];
            u = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom);
            step(($urandom % 10) != 0, a, 3'($urandom), $urandom, u,
                 ($urandom % 4) == 0, ($urandom % 4) == 0, "");
        end
        for (int k = 0; k < 4; k++) peek(k, "R7");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule